// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a 2-Kbit serial EEPROM. It sits on a three-wire serial bus that has a select, a serial clock and a data input, and it returns data on a single output with its own drive enable. Every pin is sampled in the system clock domain. A rising edge on the serial clock is found by comparing the pin with its value one system cycle earlier.

A transaction starts with a start bit, which is a 1 after any number of leading zeros. A 2-bit command follows, then an address field. The organisation pin selects the word size: sixteen-bit words when it is high, bytes when it is low. Reads stream locations continuously and wrap at the end of the array.

Writes and erases, for one location or for the whole array, run as a self-timed programming cycle once the select is dropped. While the select is held high afterwards, the data output reports busy or ready. Programming is refused until a write-enable command has been received, and reset withdraws that permission.

Top module: `eeprom_mw`

## Requirements
- R1: Reset holds `sdo_oe` low and leaves the block write-disabled, so a write issued right after reset starts no programming cycle.
- R2: `org`=1 selects 128 words of 16 bits with an 8-bit address field; its first bit is ignored and the other seven give the word. `org`=0 selects 256 bytes with a 9-bit address field; its first bit is ignored and the other eight give the byte. Byte 2w is bits 15:8 of word w, and byte 2w+1 is bits 7:0.
- R3: Zeros before the start bit are ignored. The 2-bit command after the start bit is decoded as 10 read, 01 write, 11 erase and 00 extended. Every bit is sampled on a rising serial-clock edge while `cs` is high.
- R4: A read drives a single 0 after the last address bit, then the location MSB first. Each bit changes after a rising serial-clock edge.
- R5: If the select stays high, a read continues with the next location. After the highest location it continues at location 0.
- R6: A write takes 16 or 8 data bits, MSB first, after the address. Programming begins when `cs` falls after the last data bit, and it replaces the old contents without a prior erase.
- R7: An erase sets one location, word or byte, to all ones.
- R8: Extended code 10 (erase-all) sets the whole array to ones. Extended code 01 (write-all) takes one data word, or one byte replicated into both halves of each word, and writes it to every location.
- R9: Extended code 11 enables programming and 00 disables it. These codes are the first two bits of the address field. While programming is disabled, writes and erases change nothing and start no cycle.
- R10: A programming cycle lasts PROG_CYCLES system cycles. While `cs` is high, the output shows 0 during the cycle and 1 after it. Frames clocked in during the cycle are ignored.
- R11: `sdo_oe` is low one cycle after `cs` is low, and it is low while command bits are being shifted in.
- R12: If `cs` falls before the last data bit of a write, no programming cycle starts and the memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock, sampled in the `clk` domain |
| sdi | input | 1 | Serial data in |
| org | input | 1 | Organisation: 1 = 16-bit words, 0 = bytes |
| sdo | output | 1 | Serial data out (read data or busy/ready) |
| sdo_oe | output | 1 | Drive enable for `sdo` |

## Verification
The self-timed programming engine and the serial command decoder can both be active in the same cycle. This happens when a complete write frame is clocked in, and its select is dropped, while an earlier write is still programming. The bench provokes it by starting a write to one word, then at once sending a full write frame for a second word before the ready time has passed. The outcome is judged afterwards through the normal read path: the first word must hold its new value, and the second word must still hold its old one.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {
    OPC_EXT   = 2'b00,
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10,
    OPC_ERASE = 2'b11
  } opc_t;

  typedef enum logic [1:0] {
    EXT_DIS  = 2'b00,
    EXT_FILL = 2'b01,
    EXT_WIPE = 2'b10,
    EXT_EN   = 2'b11
  } ext_t;

  typedef enum logic [1:0] {
    PG_WRITE,
    PG_ERASE,
    PG_FILL,
    PG_WIPE
  } pg_op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_DONE,
    ST_READ
  } st_t;
endpackage

// File: rtl/mw_sclk_edge.sv
module mw_sclk_edge (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sclk,
  output logic sclk_rise,
  output logic cs_fall
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs;
    end
  end

  assign sclk_rise = sclk & ~sclk_q;
  assign cs_fall   = ~cs & cs_q;
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 128,
  localparam int WA    = $clog2(WORDS),
  localparam int HALF  = WORD_W / 2
) (
  input  logic              clk,
  input  logic              we,
  input  logic [1:0]        be,
  input  logic [WA-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WA-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [HALF-1:0] mem [WORDS];
    logic [HALF-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we && be[g]) mem[waddr] <= wdata[g*HALF +: HALF];
      rd_q <= mem[raddr];
    end
    assign rdata[g*HALF +: HALF] = rd_q;
  end
endmodule

// File: rtl/mw_prog.sv
module mw_prog
  import mw_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int WORDS       = 128,
  parameter int PROG_CYCLES = 160,
  localparam int WA         = $clog2(WORDS),
  localparam int HALF       = WORD_W / 2,
  localparam int CW         = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  pg_op_t            op,
  input  logic              org,
  input  logic [WA:0]       loc,
  input  logic [WORD_W-1:0] data,
  output logic              busy,
  output logic              we,
  output logic [1:0]        be,
  output logic [WA-1:0]     waddr,
  output logic [WORD_W-1:0] wdata
);
  logic [CW-1:0]     cnt;
  pg_op_t            op_q;
  logic              org_q;
  logic [WA:0]       loc_q;
  logic [WORD_W-1:0] data_q;
  logic              single, erase;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      op_q   <= PG_WRITE;
      org_q  <= 1'b1;
      loc_q  <= '0;
      data_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      cnt    <= '0;
      op_q   <= op;
      org_q  <= org;
      loc_q  <= loc;
      data_q <= data;
    end else if (busy) begin
      if (cnt == CW'(PROG_CYCLES - 1)) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  // Single-location ops write in the first busy cycle; bulk ops sweep one word per cycle.
  assign single = (op_q == PG_WRITE) || (op_q == PG_ERASE);
  assign erase  = (op_q == PG_ERASE) || (op_q == PG_WIPE);
  assign we     = busy && (single ? (cnt == '0) : (cnt < CW'(WORDS)));
  assign waddr  = single ? (org_q ? loc_q[WA-1:0] : loc_q[WA:1]) : cnt[WA-1:0];
  assign be     = (single && !org_q) ? {~loc_q[0], loc_q[0]} : 2'b11;
  assign wdata  = erase ? '1 : (org_q ? data_q : {2{data_q[HALF-1:0]}});
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 128,
  localparam int WA    = $clog2(WORDS),
  localparam int HALF  = WORD_W / 2,
  localparam int AWF   = WA + 2,
  localparam int CNTW  = $clog2(WORD_W + AWF)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              sdi,
  input  logic              org,
  input  logic              sclk_rise,
  input  logic              cs_fall,
  input  logic              busy,
  input  logic [WORD_W-1:0] rdata,
  output logic [WA-1:0]     raddr,
  output logic              prog_start,
  output pg_op_t            prog_op,
  output logic [WA:0]       prog_loc,
  output logic [WORD_W-1:0] prog_data,
  output logic              wen,
  output logic              sdo,
  output logic              sdo_oe
);
  st_t               state;
  logic [CNTW-1:0]   bitcnt, addr_last, data_last;
  logic [AWF-2:0]    addr_sr;
  logic [AWF-1:0]    a_full;
  logic [1:0]        opc, ext_code;
  logic [WA:0]       loc, loc_next;
  logic [WORD_W-1:0] shreg, data_sr;
  logic [HALF-1:0]   byte_sel;
  logic              show_status, pend, load_req, load_cap;
  pg_op_t            pend_op;

  assign addr_last = org ? CNTW'(AWF - 2) : CNTW'(AWF - 1);
  assign data_last = org ? CNTW'(WORD_W - 1) : CNTW'(HALF - 1);
  assign a_full    = {addr_sr, sdi};
  assign ext_code  = org ? a_full[AWF-2 -: 2] : a_full[AWF-1 -: 2];
  assign loc_next  = org ? {1'b0, loc[WA-1:0] + 1'b1} : loc + 1'b1;
  assign raddr     = org ? loc[WA-1:0] : loc[WA:1];
  assign byte_sel  = loc[0] ? rdata[HALF-1:0] : rdata[WORD_W-1:HALF];

  assign prog_start = cs_fall && (state == ST_DONE) && pend && wen && !busy;
  assign prog_op    = pend_op;
  assign prog_loc   = loc;
  assign prog_data  = data_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; bitcnt <= '0; addr_sr <= '0; opc <= '0;
      loc <= '0; shreg <= '0; data_sr <= '0; wen <= 1'b0;
      show_status <= 1'b0; pend <= 1'b0; pend_op <= PG_WRITE;
      load_req <= 1'b0; load_cap <= 1'b0; sdo <= 1'b0; sdo_oe <= 1'b0;
    end else begin
      load_req <= 1'b0;
      load_cap <= load_req;
      if (load_cap) begin
        shreg <= org ? rdata : {byte_sel, {HALF{1'b0}}};
        loc   <= loc_next;
      end
      if (prog_start) show_status <= 1'b1;

      // Output enable: status while idle, read data while streaming, else released.
      if (!cs) sdo_oe <= 1'b0;
      else if (state == ST_IDLE && show_status) begin
        sdo_oe <= 1'b1;
        sdo    <= ~busy;
      end else if (state != ST_READ) sdo_oe <= 1'b0;

      if (!cs) state <= ST_IDLE;
      else if (sclk_rise && !busy) begin
        case (state)
          ST_IDLE: if (sdi) begin
            state <= ST_OPC; bitcnt <= '0; addr_sr <= '0;
            show_status <= 1'b0; pend <= 1'b0;
          end
          ST_OPC: begin
            opc <= {opc[0], sdi};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == CNTW'(1)) begin state <= ST_ADDR; bitcnt <= '0; end
          end
          ST_ADDR: begin
            addr_sr <= a_full[AWF-2:0];
            bitcnt  <= bitcnt + 1'b1;
            if (bitcnt == addr_last) begin
              bitcnt <= '0;
              loc    <= org ? {1'b0, a_full[WA-1:0]} : a_full[WA:0];
              state  <= ST_DONE;
              case (opc_t'(opc))
                OPC_READ:  begin state <= ST_READ; load_req <= 1'b1; sdo <= 1'b0; sdo_oe <= 1'b1; end
                OPC_WRITE: begin state <= ST_DATA; pend_op <= PG_WRITE; end
                OPC_ERASE: begin pend <= 1'b1; pend_op <= PG_ERASE; end
                default: case (ext_t'(ext_code))
                  EXT_EN:   wen <= 1'b1;
                  EXT_DIS:  wen <= 1'b0;
                  EXT_WIPE: begin pend <= 1'b1; pend_op <= PG_WIPE; end
                  default:  begin state <= ST_DATA; pend_op <= PG_FILL; end
                endcase
              endcase
            end
          end
          ST_DATA: begin
            data_sr <= {data_sr[WORD_W-2:0], sdi};
            bitcnt  <= bitcnt + 1'b1;
            if (bitcnt == data_last) begin state <= ST_DONE; pend <= 1'b1; end
          end
          ST_READ: begin
            sdo    <= shreg[WORD_W-1];
            shreg  <= {shreg[WORD_W-2:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == data_last) begin bitcnt <= '0; load_req <= 1'b1; end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_mw.sv
module eeprom_mw
  import mw_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int WORDS       = 128,
  parameter int PROG_CYCLES = 160,
  localparam int WA         = $clog2(WORDS)
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  input  logic org,
  output logic sdo,
  output logic sdo_oe
);
  logic              sclk_rise, cs_fall, busy, wen, prog_start;
  logic              mem_we;
  logic [1:0]        mem_be;
  logic [WA-1:0]     mem_waddr, mem_raddr;
  logic [WORD_W-1:0] mem_wdata, mem_rdata, prog_data;
  logic [WA:0]       prog_loc;
  pg_op_t            prog_op;

  mw_sclk_edge u_edge (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk),
    .sclk_rise(sclk_rise), .cs_fall(cs_fall)
  );

  mw_ctrl #(.WORD_W(WORD_W), .WORDS(WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .cs(cs), .sdi(sdi), .org(org),
    .sclk_rise(sclk_rise), .cs_fall(cs_fall), .busy(busy),
    .rdata(mem_rdata), .raddr(mem_raddr), .prog_start(prog_start),
    .prog_op(prog_op), .prog_loc(prog_loc), .prog_data(prog_data),
    .wen(wen), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  mw_prog #(.WORD_W(WORD_W), .WORDS(WORDS), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk(clk), .rst(rst), .start(prog_start), .op(prog_op), .org(org),
    .loc(prog_loc), .data(prog_data), .busy(busy), .we(mem_we),
    .be(mem_be), .waddr(mem_waddr), .wdata(mem_wdata)
  );

  mw_array #(.WORD_W(WORD_W), .WORDS(WORDS)) u_array (
    .clk(clk), .we(mem_we), .be(mem_be), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/mw_checker.sv
module mw_checker (
  input logic clk,
  input logic rst,
  input logic cs,
  input logic sdo,
  input logic sdo_oe,
  input logic wen,
  input logic busy
);
  // R11: output released one cycle after deselect
  a_r11_hiz_deselected: assert property (@(posedge clk) disable iff (rst)
    !cs |=> !sdo_oe);

  // R1: quiet and write-disabled right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !sdo_oe && !wen));

  // R9: a programming cycle only begins while enabled
  a_r9_prog_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wen);

  // R10: status reads low while the cycle runs
  a_r10_busy_shows_low: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && sdo_oe) |-> !sdo);

  // R4: output is only driven after a selected cycle
  a_r4_drive_needs_cs: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> $past(cs));
endmodule

bind eeprom_mw mw_checker u_chk (
  .clk(clk), .rst(rst), .cs(cs), .sdo(sdo),
  .sdo_oe(sdo_oe), .wen(wen), .busy(busy)
);

// File: tb/tb_eeprom_mw.sv
`timescale 1ns/1ps
module tb_eeprom_mw;
  localparam int PROG = 160;

  logic clk, rst, cs, sclk, sdi, org;
  logic sdo, sdo_oe;
  int   n_chk = 0, n_err = 0;

  eeprom_mw #(.WORD_W(16), .WORDS(128), .PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .sdi(sdi), .org(org),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {org, 9-bit address field, data}
  localparam logic [25:0] VEC [6] = '{
    {1'b1, 9'h005, 16'hA55A},
    {1'b1, 9'h0FF, 16'h1234},
    {1'b0, 9'h020, 16'h003C},
    {1'b0, 9'h121, 16'h00C3},
    {1'b1, 9'h040, 16'h0F0F},
    {1'b0, 9'h1FE, 16'h0077}
  };

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic q);
    sdi = b; sclk = 1'b1; clk_n(3);
    q = sdo; sclk = 1'b0; clk_n(3);
  endtask

  task automatic cs_gap();
    cs = 1'b0; sdi = 1'b0; clk_n(4);
  endtask

  task automatic send_head(input logic [1:0] opc, input logic o, input logic [8:0] a,
                           input int lead, output logic dq);
    logic q;
    org = o; cs = 1'b1; clk_n(2);
    for (int i = 0; i < lead; i++) sbit(1'b0, q);
    sbit(1'b1, q); sbit(opc[1], q); sbit(opc[0], q);
    for (int i = (o ? 7 : 8); i >= 0; i--) sbit(a[i], q);
    dq = q;
  endtask

  task automatic read_n(input logic o, input logic [8:0] a, input int cnt, input int lead,
                        output logic [31:0] got);
    logic q, dq;
    send_head(2'b10, o, a, lead, dq);
    chk("R4 dummy zero", {31'b0, dq}, 32'h0);
    got = '0;
    for (int i = 0; i < cnt * (o ? 16 : 8); i++) begin
      sbit(1'b0, q);
      got = {got[30:0], q};
    end
    cs_gap();
  endtask

  task automatic write_n(input logic o, input logic [8:0] a, input logic [15:0] d, input int nbits);
    logic q;
    int   w;
    w = o ? 16 : 8;
    send_head(2'b01, o, a, 0, q);
    for (int i = 0; i < nbits; i++) sbit(d[w-1-i], q);
  endtask

  task automatic end_busy(input logic check_low);
    cs = 1'b0; clk_n(4); cs = 1'b1; clk_n(2);
    if (check_low) chk("R10 busy shown low", {30'b0, sdo_oe, sdo}, 32'h2);
    clk_n(PROG + 6);
    chk("R10 ready shown high", {30'b0, sdo_oe, sdo}, 32'h3);
    cs_gap();
  endtask

  task automatic expect_idle(input string req);
    cs = 1'b0; clk_n(4); cs = 1'b1; clk_n(2);
    chk(req, {31'b0, sdo_oe}, 32'h0);
    cs_gap();
  endtask

  task automatic ext(input logic [1:0] code);
    logic q;
    send_head(2'b00, 1'b1, {1'b0, code, 6'b0}, 0, q);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] got;
    logic        q;
    cs = 0; sclk = 0; sdi = 0; org = 1; rst = 1;
    clk_n(3); rst = 0; clk_n(1);
    chk("R1 sdo_oe low after reset", {31'b0, sdo_oe}, 32'h0);

    // R1: write right after reset is refused
    write_n(1'b1, 9'h003, 16'h0000, 16);
    expect_idle("R1 no cycle while disabled after reset");

    // R8 erase-all, then R9 disable blocks a write
    ext(2'b11); cs_gap();
    ext(2'b10); end_busy(1'b1);
    ext(2'b00); cs_gap();
    write_n(1'b1, 9'h003, 16'h0000, 16);
    expect_idle("R9 no cycle after disable");
    read_n(1'b1, 9'h003, 1, 0, got);
    chk("R9 R8 word kept erased", got, 32'h0000FFFF);
    ext(2'b11); cs_gap();

    // R6 R2: vector table of write then read-back
    foreach (VEC[k]) begin
      write_n(VEC[k][25], VEC[k][24:16], VEC[k][15:0], VEC[k][25] ? 16 : 8);
      end_busy(1'b0);
      read_n(VEC[k][25], VEC[k][24:16], 1, 0, got);
      chk("R6 read back", got, VEC[k][25] ? {16'h0, VEC[k][15:0]} : {24'h0, VEC[k][7:0]});
    end

    read_n(1'b1, 9'h010, 1, 0, got);
    chk("R2 bytes 32,33 form word 16", got, 32'h00003CC3);

    // R5 wrap with R3 leading zeros
    read_n(1'b1, 9'h07F, 2, 2, got);
    chk("R5 R3 x16 stream wraps", got, 32'h7734FFFF);
    read_n(1'b0, 9'h0FF, 2, 0, got);
    chk("R5 x8 stream wraps", got, 32'h000034FF);

    // R7 erase one byte and one word
    send_head(2'b11, 1'b0, 9'h021, 0, q); end_busy(1'b1);
    read_n(1'b1, 9'h010, 1, 0, got);
    chk("R7 byte erase", got, 32'h00003CFF);
    send_head(2'b11, 1'b1, 9'h005, 0, q); end_busy(1'b0);
    read_n(1'b1, 9'h005, 1, 0, got);
    chk("R7 word erase", got, 32'h0000FFFF);

    // R8 write-all
    ext(2'b01);
    for (int i = 15; i >= 0; i--) sbit(16'hBEEF >> i, q);
    end_busy(1'b1);
    read_n(1'b1, 9'h000, 1, 0, got); chk("R8 fill word 0", got, 32'h0000BEEF);
    read_n(1'b1, 9'h07F, 1, 0, got); chk("R8 fill word 127", got, 32'h0000BEEF);
    read_n(1'b0, 9'h021, 1, 0, got); chk("R8 fill byte 33", got, 32'h000000EF);

    // R10: frame during busy is ignored
    write_n(1'b1, 9'h002, 16'h1111, 16);
    cs = 1'b0; clk_n(4);
    write_n(1'b1, 9'h003, 16'h2222, 16);
    cs = 1'b0; clk_n(PROG + 10); cs = 1'b1; clk_n(2);
    chk("R10 ready after overlap", {30'b0, sdo_oe, sdo}, 32'h3);
    cs_gap();
    read_n(1'b1, 9'h003, 1, 0, got); chk("R10 busy frame ignored", got, 32'h0000BEEF);
    read_n(1'b1, 9'h002, 1, 0, got); chk("R10 first write landed", got, 32'h00001111);

    // R11: released during command entry and after deselect
    cs = 1'b1; clk_n(2);
    sbit(1'b1, q); sbit(1'b1, q); sbit(1'b0, q);
    chk("R11 hi-Z during command", {31'b0, sdo_oe}, 32'h0);
    cs = 1'b0; clk_n(2);
    chk("R11 hi-Z deselected", {31'b0, sdo_oe}, 32'h0);
    cs_gap();

    // R12: truncated write
    write_n(1'b1, 9'h009, 16'h0000, 10);
    expect_idle("R12 no cycle on short frame");
    read_n(1'b1, 9'h009, 1, 0, got); chk("R12 word unchanged", got, 32'h0000BEEF);

    // R1: reset revokes enable
    rst = 1'b1; clk_n(2); rst = 1'b0; clk_n(1);
    write_n(1'b1, 9'h009, 16'h0000, 16);
    expect_idle("R1 reset disables writes");
    read_n(1'b1, 9'h009, 1, 0, got); chk("R1 word unchanged after reset", got, 32'h0000BEEF);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule